// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer with Selectable Count Source

This block is a periodic tick generator for a processor subsystem. Software loads a 24-bit reload value and clears the live count. It then enables counting. From then on the counter steps down towards zero, reloads, and starts over. Each pass from one to zero sets a sticky wrap flag. When interrupts are enabled, that pass also raises a single-cycle interrupt request. A full period is therefore the reload value plus one count steps.

Steps come from one of two sources. The first is every cycle of the fast clock. The second is a slower reference tick. A free-running divider makes that tick as a one-cycle enable pulse in the fast clock domain, and a 2-bit code picks the divide ratio. The timer's own control register has a source-select bit. A separate system configuration register holds a force bit that puts the counter on the fast clock whatever the source-select bit says. The same register holds the divide code.

A small sequencer inside the counter has two states, ST_HALT and ST_RUN. The transition ST_HALT to ST_RUN is taken on the edge after the enable bit is seen set. The transition ST_RUN to ST_HALT is taken on the edge after it is seen clear. Count steps happen only in ST_RUN.

Top module: `tick_timer`

## Requirements
- R1: After reset all four registers read zero and `tick_irq` is low.
- R2: The register at address 1 holds the reload value. Only bits 23:0 are stored, and bits 31:24 read zero. Bits 31:24 of the live count (address 2) also always read zero.
- R3: The control register is at address 0: bit 0 enables counting, bit 1 enables interrupts, bit 2 selects the fast source. In the system configuration register at address 3, only bit 25 and bits 27:26 are stored. All other bits of both registers read zero and ignore writes, including control bit 16.
- R4: With control bit 2 set, the counter takes one step per fast clock cycle, so interrupts come every reload+1 cycles.
- R5: With control bit 2 and system bit 25 both clear, the counter steps once per reference tick. Divide codes 0, 1, 2 and 3 in bits 27:26 give ratios of 4, 8, 16 and 32, so the period is (reload+1)*ratio cycles.
- R6: System bit 25 set forces one step per fast cycle even when control bit 2 is clear.
- R7: A step taken at a count of zero loads the reload value.
- R8: Any write to address 2 sets the count to zero, whatever data is written, and clears the wrap flag. The next step then loads the reload value.
- R9: The wrap flag (control bit 16) is set by a step from one to zero. A read of the control register returns the set flag and clears it. If a wrap and a clear happen in the same cycle, the set wins.
- R10: `tick_irq` is high for exactly one cycle, in the cycle after the step that reached zero, and only when control bit 1 is set.
- R11: With a reload value of zero the count stays at zero, and neither the flag nor `tick_irq` is ever set.
- R12: Once the counter is back in ST_HALT (one cycle after bit 0 clears), the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset, applied at a clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (its side effects apply at the edge) |
| bus_addr | input | 2 | Register select: 0 control, 1 reload, 2 count, 3 system configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_irq | output | 1 | Interrupt request pulse |

## Verification
Read data is combinational, so a register read returns state as of the last edge. Each write takes effect at the edge on which it is strobed, and the bench reads back at the falling edge just after it. After a count write, the count reads zero at once, the reload value one cycle later, and the reload value minus one a further cycle on. The interrupt is registered: it appears one cycle after the step that reached zero. The bench therefore measures periods as whole-cycle distances between pulses seen at falling edges, which makes the period independent of when enable starts. The one-cycle lag between setting or clearing enable and entering or leaving ST_RUN is covered by waiting several cycles before any check that depends on it.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_SYSCFG  = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;
    localparam int SYS_FORCE_BIT = 25;
    localparam int SYS_DIV_LSB   = 26;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/tick_refdiv.sv
module tick_refdiv #(
    parameter int CODE_W    = 2,
    parameter int BASE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              ref_tick
);
    localparam int MAX_LOG2 = BASE_LOG2 + (1 << CODE_W) - 1;

    logic [MAX_LOG2-1:0] cnt_q;
    logic [MAX_LOG2:0]   ratio;
    logic [MAX_LOG2-1:0] last;

    always_comb begin
        ratio    = (MAX_LOG2+1)'(1) << (BASE_LOG2 + int'(div_code));
        last     = MAX_LOG2'(ratio - 1'b1);
        ref_tick = (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (ref_tick) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tick_regfile.sv
module tick_regfile
    import tick_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int DATA_W     = 32,
    parameter int DIV_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [1:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [CNT_W-1:0]      cur,
    input  logic                  flag,
    output logic                  en,
    output logic                  ie,
    output logic                  src_fast,
    output logic                  force_fast,
    output logic [DIV_CODE_W-1:0] div_code,
    output logic [CNT_W-1:0]      reload,
    output logic                  wr_cur,
    output logic                  rd_ctrl
);
    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_cur  = bus_wr && (sel == REG_CURRENT);
        rd_ctrl = bus_rd && (sel == REG_CTRL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            ie         <= 1'b0;
            src_fast   <= 1'b0;
            force_fast <= 1'b0;
            div_code   <= '0;
            reload     <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_CTRL: begin
                    en       <= bus_wdata[CTRL_EN_BIT];
                    ie       <= bus_wdata[CTRL_IE_BIT];
                    src_fast <= bus_wdata[CTRL_SRC_BIT];
                end
                REG_RELOAD:  reload <= bus_wdata[CNT_W-1:0];
                REG_SYSCFG: begin
                    force_fast <= bus_wdata[SYS_FORCE_BIT];
                    div_code   <= bus_wdata[SYS_DIV_LSB +: DIV_CODE_W];
                end
                REG_CURRENT: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en;
                bus_rdata[CTRL_IE_BIT]   = ie;
                bus_rdata[CTRL_SRC_BIT]  = src_fast;
                bus_rdata[CTRL_FLAG_BIT] = flag;
            end
            REG_RELOAD:  bus_rdata[CNT_W-1:0] = reload;
            REG_CURRENT: bus_rdata[CNT_W-1:0] = cur;
            REG_SYSCFG: begin
                bus_rdata[SYS_FORCE_BIT]                 = force_fast;
                bus_rdata[SYS_DIV_LSB +: DIV_CODE_W]     = div_code;
            end
        endcase
    end
endmodule

// File: rtl/tick_core.sv
module tick_core
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ie,
    input  logic             tick_ok,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr_cur,
    input  logic             rd_ctrl,
    output logic [CNT_W-1:0] cur,
    output logic             flag,
    output logic             irq,
    output logic             running
);
    run_state_e state_q, state_d;
    logic step, wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_HALT: if (en) state_d = ST_RUN;
            ST_RUN: begin
                step = tick_ok && !wr_cur;
                if (!en) state_d = ST_HALT;
            end
        endcase
        wrap    = step && (cur == CNT_W'(1));
        running = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (wr_cur)    cur <= '0;
            else if (step) cur <= (cur == '0) ? reload : cur - 1'b1;
            if (wrap)                   flag <= 1'b1;
            else if (wr_cur || rd_ctrl) flag <= 1'b0;
            irq <= wrap && ie;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W         = 24,
    parameter int DATA_W        = 32,
    parameter int DIV_CODE_W    = 2,
    parameter int DIV_BASE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    logic                  en_w, ie_w, src_w, force_w;
    logic [DIV_CODE_W-1:0] div_code_w;
    logic [CNT_W-1:0]      reload_w, cur_w;
    logic                  flag_w, ref_tick_w, tick_ok_w;
    logic                  wr_cur_w, rd_ctrl_w, running_w;

    tick_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_CODE_W(DIV_CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur(cur_w), .flag(flag_w), .en(en_w), .ie(ie_w), .src_fast(src_w),
        .force_fast(force_w), .div_code(div_code_w), .reload(reload_w),
        .wr_cur(wr_cur_w), .rd_ctrl(rd_ctrl_w)
    );

    tick_refdiv #(.CODE_W(DIV_CODE_W), .BASE_LOG2(DIV_BASE_LOG2)) u_div (
        .clk(clk), .rst_n(rst_n), .div_code(div_code_w), .ref_tick(ref_tick_w)
    );

    assign tick_ok_w = force_w || src_w || ref_tick_w;

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_w), .ie(ie_w), .tick_ok(tick_ok_w),
        .reload(reload_w), .wr_cur(wr_cur_w), .rd_ctrl(rd_ctrl_w),
        .cur(cur_w), .flag(flag_w), .irq(tick_irq), .running(running_w)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic              ie,
    input logic              src,
    input logic              force_fast,
    input logic              ref_tick,
    input logic              running,
    input logic              wr_cur,
    input logic              flag,
    input logic [CNT_W-1:0]  cur,
    input logic [CNT_W-1:0]  reload
);
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> $past(ie)); // R10
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq); // R10
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (cur == '0)); // R10
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> flag); // R9
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_cur) |=> $stable(cur)); // R12
    AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && cur == '0) |=> (cur == '0)); // R11
    AST_SLOW_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !force_fast && !src && !ref_tick && !wr_cur) |=> $stable(cur)); // R5
    AST_CUR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R2
endmodule

bind tick_timer tick_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq), .ie(ie_w), .src(src_w), .force_fast(force_w),
    .ref_tick(ref_tick_w), .running(running_w), .wr_cur(wr_cur_w),
    .flag(flag_w), .cur(cur_w), .reload(reload_w)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_irq(tick_irq)
    );

    // columns: system config, control, reload, expected period in cycles
    localparam int unsigned TBL [7][4] = '{
        '{32'h0000_0000, 32'h7, 5, 6},    // R4 fast
        '{32'h0000_0000, 32'h3, 3, 16},   // R5 code 0 ratio 4
        '{32'h0400_0000, 32'h3, 2, 24},   // R5 code 1 ratio 8
        '{32'h0800_0000, 32'h3, 1, 32},   // R5 code 2 ratio 16
        '{32'h0C00_0000, 32'h3, 1, 64},   // R5 code 3 ratio 32
        '{32'h0E00_0000, 32'h3, 4, 5},    // R6 force overrides src clear
        '{32'h0200_0000, 32'h7, 7, 8}     // R6 force with src set
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_irq && n < limit);
    endtask

    task automatic count_irq(input int cycles, output int k);
        k = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_irq) k++;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        int n, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 irq low", {31'b0, tick_irq}, 32'h0);

        // R3 / R2 unused bits and widths
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R3 control bits", v, 32'h7);
        wr(2'd0, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R3 sysconfig bits", v, 32'h0E00_0000);
        wr(2'd3, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R2 reload width", v, 32'h00FF_FFFF);

        // R4 R5 R6 R7 R10 table of periods
        for (int t = 0; t < 7; t++) begin
            wr(2'd0, 32'h0);
            wr(2'd3, TBL[t][0]);
            wr(2'd1, TBL[t][2]);
            wr(2'd2, 32'h0);
            wr(2'd0, TBL[t][1]);
            wait_irq(2000, n);
            wait_irq(5000, n);
            check($sformatf("R4/R5/R6/R7 period entry %0d", t), n, TBL[t][3]);
            @(negedge clk);
            check("R10 irq single cycle", {31'b0, tick_irq}, 32'h0);
        end
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h0);

        // R8 count write clears, then reload
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h5);
        repeat (10) @(negedge clk);
        wr(2'd2, 32'hABCD);
        rd(2'd2, v); check("R8 count cleared", v, 32'd0);
        rd(2'd2, v); check("R8 reload after clear", v, 32'd100);
        rd(2'd2, v); check("R7 step after reload", v, 32'd99);

        // R9 flag set and cleared by control read
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd20);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h7);
        wait_irq(200, n);
        rd(2'd0, v); check("R9 flag set on wrap", v, 32'h0001_0007);
        rd(2'd0, v); check("R9 flag cleared by read", v, 32'h0000_0007);
        wait_irq(200, n);
        wr(2'd2, 32'h0);
        rd(2'd0, v); check("R8 flag cleared by count write", v, 32'h0000_0007);

        // R10 interrupt disabled
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h5);
        count_irq(40, k);
        check("R10 no irq when disabled", k, 0);
        rd(2'd0, v); check("R9 flag without irq", v, 32'h0001_0005);

        // R11 zero reload
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h7);
        count_irq(40, k);
        check("R11 no irq", k, 0);
        rd(2'd2, v); check("R11 count stays zero", v, 32'h0);
        rd(2'd0, v); check("R11 flag never set", v, 32'h7);

        // R12 halt holds count
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd1000);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h5);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h0);
        repeat (2) @(negedge clk);
        rd(2'd2, v);
        repeat (10) @(negedge clk);
        rd(2'd2, v2);
        check("R12 count held", v2, v);
        check("R12 count nonzero", {31'b0, (v != 0)}, 32'h1);

        summary();
    end
endmodule